// File: doc/BRIEF.md
# Prefix-Switched Instruction Format Decoder

This block sits behind a byte-wide instruction fetch port. It gathers one to four bytes per instruction, works out whether the instruction is a one-, two-, three- or four-byte form, and emits one decoded record per instruction. The record carries the opcode, the two register nibbles of a register form, the six addressing flags and the displacement or absolute address of a memory form. It also flags invalid opcodes, the no-op, the halt and the prefix byte.

Two opcode maps are held: a base map and an extended map. The extended map reuses several base opcode values with other meanings, for vector arithmetic and vector register load/store. A one-byte prefix arms the extended map for exactly the next instruction. Once that instruction has been decoded, whether valid or not, decoding returns to the base map. A halt stops all further fetching until reset. Effective-address arithmetic and execution happen downstream.

Top module: `pfx_fmt_decoder`

## Requirements
- R1: A synchronous reset (active high) clears the outputs: `dec_valid`=0 and `halted`=0. After reset `fetch_ready`=1, and any pending prefix is dropped, so the first instruction decodes in the base map (`dec_ext_map`=0).
- R2: In the base map, bytes C0, C4, C8, F0, F4, F8 and the no-op F1, halt F2 and prefix EE are one-byte forms. They give `dec_fmt`=0 with `dec_opcode` equal to the byte, and all other fields are zero. F1 sets `dec_nop`.
- R3: Two-byte forms give `dec_fmt`=1. `dec_r1` is the high nibble of the second byte and `dec_r2` is its low nibble. The base two-byte opcodes are the multiples of 4 from 90 to B8.
- R4: The base memory-form opcodes are the multiples of 4 from 00 to 88, plus D0, D4, D8, DC, E0, E8 and EC. For a memory form, `dec_opcode` is the first byte with bits 1:0 cleared. `dec_flags`={n,i,x,b,p,e}, where n and i are bits 1 and 0 of the first byte and x, b, p, e are bits 7..4 of the second byte.
- R5: With e (second byte bit 4) clear, the instruction is 3 bytes: `dec_fmt`=2 and `dec_addr`={zero, second byte[3:0], third byte}. With e set, it is 4 bytes: `dec_fmt`=3 and `dec_addr`={second byte[3:0], third byte, fourth byte}.
- R6: The format is first looked up with the full first byte. A one- or two-byte entry is used as is. Otherwise the byte with bits 1:0 cleared must be a memory-form entry, or the byte is invalid. For example, 91 and F3 are invalid, and 03 is the memory form 00.
- R7: An opcode with no entry in the active map consumes exactly one byte. It decodes with `dec_invalid`=1, `dec_fmt`=0, `dec_opcode` equal to the byte, and all other fields zero.
- R8: The prefix EE, decoded in the base map, sets `dec_prefix`. The next instruction decodes in the extended map with `dec_ext_map`=1, and the one after it in the base map again.
- R9: The extended map holds only the two-byte forms 90, 94, 98, 9C and the memory forms 00, 04, 0C, 18, 1C, 20, 24, 68, 7C, 84. Every other opcode is invalid there, including EE, F1, F2 and B4.
- R10: Any record decoded in the extended map, an invalid one included, returns decoding to the base map.
- R11: Halt F2 in the base map sets `dec_halt` and `halted`. From the next cycle `fetch_ready` stays low and no record appears until reset.
- R12: A byte is taken only in a cycle with `fetch_valid` and `fetch_ready` both high. `dec_valid` is a one-cycle pulse in the cycle after the last byte of an instruction is taken. Idle cycles between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch byte present |
| fetch_byte | input | 8 | Instruction byte |
| fetch_ready | output | 1 | Decoder takes a byte this cycle |
| dec_valid | output | 1 | One-cycle record strobe |
| dec_ext_map | output | 1 | Record decoded in the extended map |
| dec_fmt | output | 2 | Length form: 0..3 for 1..4 bytes |
| dec_opcode | output | 8 | Opcode (masked for memory forms) |
| dec_r1 | output | 4 | First register nibble |
| dec_r2 | output | 4 | Second register nibble |
| dec_flags | output | 6 | {n,i,x,b,p,e} |
| dec_addr | output | 20 | Displacement or absolute address |
| dec_invalid | output | 1 | No entry in the active map |
| dec_halt | output | 1 | Halt decoded |
| dec_nop | output | 1 | No-op decoded |
| dec_prefix | output | 1 | Prefix decoded |
| halted | output | 1 | Decoder stopped by halt |

## Verification
The bench builds the decoder with its default parameters: prefix EE, no-op F1 and halt F2. With these values, the halt byte after a prefix lands in the extended map and must decode as invalid rather than stop the decoder. A reference model in the bench tracks the armed-prefix state and replays random byte streams through it, with random idle gaps between bytes. About a third of the instructions are preceded by a prefix, so the one-shot return to the base map is exercised after valid, invalid and repeated-prefix instructions alike.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int FLAG_W = 6;
  localparam int DISP_W = BYTE_W + NIB_W;
  localparam int ADDR_W = DISP_W + BYTE_W;
  localparam int E_POS  = 4;
  localparam logic [BYTE_W-1:0] OP_MASK = 8'hFC;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_F1   = 2'd1,
    CLS_F2   = 2'd2,
    CLS_F34  = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    FMT_1 = 2'd0,
    FMT_2 = 2'd1,
    FMT_3 = 2'd2,
    FMT_4 = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    ST_OP = 2'd0,
    ST_B1 = 2'd1,
    ST_B2 = 2'd2,
    ST_B3 = 2'd3
  } gather_e;

  // Base opcode map.
  function automatic op_class_e base_class(input logic [BYTE_W-1:0] b,
                                           input logic [BYTE_W-1:0] pre_op,
                                           input logic [BYTE_W-1:0] nop_op,
                                           input logic [BYTE_W-1:0] halt_op);
    if (b == pre_op || b == nop_op || b == halt_op) return CLS_F1;
    if (b == 8'hC0 || b == 8'hC4 || b == 8'hC8 ||
        b == 8'hF0 || b == 8'hF4 || b == 8'hF8) return CLS_F1;
    if (b[1:0] == 2'b00 && b >= 8'h90 && b <= 8'hB8) return CLS_F2;
    if (b[1:0] == 2'b00 &&
        (b <= 8'h88 || (b >= 8'hD0 && b <= 8'hE0) || b == 8'hE8 || b == 8'hEC))
      return CLS_F34;
    return CLS_NONE;
  endfunction

  // Extended opcode map: vector operations only.
  function automatic op_class_e ext_class(input logic [BYTE_W-1:0] b);
    case (b)
      8'h90, 8'h94, 8'h98, 8'h9C:                 return CLS_F2;
      8'h18, 8'h1C, 8'h20, 8'h24,
      8'h00, 8'h04, 8'h68,
      8'h0C, 8'h7C, 8'h84:                        return CLS_F34;
      default:                                    return CLS_NONE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] mem_addr(input fmt_e f,
                                                 input logic [BYTE_W-1:0] b1,
                                                 input logic [BYTE_W-1:0] b2,
                                                 input logic [BYTE_W-1:0] b3);
    if (f == FMT_4) return {b1[NIB_W-1:0], b2, b3};
    return {{BYTE_W{1'b0}}, b1[NIB_W-1:0], b2};
  endfunction

endpackage

// File: rtl/pfx_map_rom.sv
module pfx_map_rom
  import pfx_dec_pkg::*;
#(
  parameter bit                EXT_MAP = 1'b0,
  parameter logic [BYTE_W-1:0] PRE_OP  = 8'hEE,
  parameter logic [BYTE_W-1:0] NOP_OP  = 8'hF1,
  parameter logic [BYTE_W-1:0] HALT_OP = 8'hF2
) (
  input  logic [BYTE_W-1:0] full_byte,
  input  logic [BYTE_W-1:0] masked_byte,
  output op_class_e         full_cls,
  output op_class_e         masked_cls
);

  generate
    if (EXT_MAP) begin : g_ext
      assign full_cls   = ext_class(full_byte);
      assign masked_cls = ext_class(masked_byte);
    end else begin : g_base
      assign full_cls   = base_class(full_byte, PRE_OP, NOP_OP, HALT_OP);
      assign masked_cls = base_class(masked_byte, PRE_OP, NOP_OP, HALT_OP);
    end
  endgenerate

endmodule

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_dec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PRE_OP  = 8'hEE,
  parameter logic [BYTE_W-1:0] NOP_OP  = 8'hF1,
  parameter logic [BYTE_W-1:0] HALT_OP = 8'hF2
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              ext_sel,
  output logic              is_f1,
  output logic              is_f2,
  output logic              is_inv,
  output logic              is_prefix,
  output logic              is_nop,
  output logic              is_halt
);

  localparam int N_MAPS = 2;

  logic [BYTE_W-1:0] masked;
  op_class_e         full_c   [N_MAPS];
  op_class_e         masked_c [N_MAPS];
  op_class_e         sel_full;
  op_class_e         sel_masked;
  logic              is_mem;

  assign masked = byte_in & OP_MASK;

  // Both maps are looked up in parallel; the armed prefix picks one.
  for (genvar m = 0; m < N_MAPS; m++) begin : g_map
    pfx_map_rom #(
      .EXT_MAP (m == 1),
      .PRE_OP  (PRE_OP),
      .NOP_OP  (NOP_OP),
      .HALT_OP (HALT_OP)
    ) rom_i (
      .full_byte   (byte_in),
      .masked_byte (masked),
      .full_cls    (full_c[m]),
      .masked_cls  (masked_c[m])
    );
  end

  assign sel_full   = ext_sel ? full_c[1]   : full_c[0];
  assign sel_masked = ext_sel ? masked_c[1] : masked_c[0];

  // Full byte decides first; the masked opcode only matters for memory forms.
  always_comb begin
    is_f1  = (sel_full == CLS_F1);
    is_f2  = (sel_full == CLS_F2);
    is_mem = !is_f1 && !is_f2 && (sel_masked == CLS_F34);
    is_inv = !(is_f1 || is_f2 || is_mem);
  end

  assign is_prefix = !ext_sel && is_f1 && (byte_in == PRE_OP);
  assign is_nop    = !ext_sel && is_f1 && (byte_in == NOP_OP);
  assign is_halt   = !ext_sel && is_f1 && (byte_in == HALT_OP);

endmodule

// File: rtl/pfx_field_extract.sv
module pfx_field_extract
  import pfx_dec_pkg::*;
(
  input  fmt_e              fmt,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] b2,
  input  logic [BYTE_W-1:0] b3,
  output logic [BYTE_W-1:0] opcode,
  output logic [NIB_W-1:0]  r1,
  output logic [NIB_W-1:0]  r2,
  output logic [FLAG_W-1:0] flags,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    opcode = b0;
    r1     = '0;
    r2     = '0;
    flags  = '0;
    addr   = '0;
    case (fmt)
      FMT_2: begin
        r1 = b1[BYTE_W-1:NIB_W];
        r2 = b1[NIB_W-1:0];
      end
      FMT_3, FMT_4: begin
        opcode = b0 & OP_MASK;
        flags  = {b0[1:0], b1[BYTE_W-1:NIB_W]};
        addr   = mem_addr(fmt, b1, b2, b3);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pfx_fmt_decoder.sv
module pfx_fmt_decoder
  import pfx_dec_pkg::*;
#(
  parameter logic [7:0] PRE_OP  = 8'hEE,
  parameter logic [7:0] NOP_OP  = 8'hF1,
  parameter logic [7:0] HALT_OP = 8'hF2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fetch_valid,
  input  logic [7:0]  fetch_byte,
  output logic        fetch_ready,
  output logic        dec_valid,
  output logic        dec_ext_map,
  output logic [1:0]  dec_fmt,
  output logic [7:0]  dec_opcode,
  output logic [3:0]  dec_r1,
  output logic [3:0]  dec_r2,
  output logic [5:0]  dec_flags,
  output logic [19:0] dec_addr,
  output logic        dec_invalid,
  output logic        dec_halt,
  output logic        dec_nop,
  output logic        dec_prefix,
  output logic        halted
);

  gather_e           state_q, state_d;
  logic [BYTE_W-1:0] b0_q, b1_q, b2_q;
  logic              kind_f2_q;
  logic              pending_q;
  logic              halted_q;

  // Named events.
  logic accept;
  logic emit;
  fmt_e emit_fmt;
  logic [BYTE_W-1:0] e_b0, e_b1, e_b2, e_b3;
  logic emit_inv, emit_pre, emit_nop, emit_halt;

  logic c_f1, c_f2, c_inv, c_pre, c_nop, c_halt;

  logic [BYTE_W-1:0] x_opcode;
  logic [NIB_W-1:0]  x_r1, x_r2;
  logic [FLAG_W-1:0] x_flags;
  logic [ADDR_W-1:0] x_addr;

  fmt_e dec_fmt_q;

  assign fetch_ready = !halted_q;
  assign accept      = fetch_valid && fetch_ready;
  assign halted      = halted_q;
  assign dec_fmt     = dec_fmt_q;

  pfx_classify #(
    .PRE_OP  (PRE_OP),
    .NOP_OP  (NOP_OP),
    .HALT_OP (HALT_OP)
  ) cls_i (
    .byte_in   (fetch_byte),
    .ext_sel   (pending_q),
    .is_f1     (c_f1),
    .is_f2     (c_f2),
    .is_inv    (c_inv),
    .is_prefix (c_pre),
    .is_nop    (c_nop),
    .is_halt   (c_halt)
  );

  always_comb begin
    state_d   = state_q;
    emit      = 1'b0;
    emit_fmt  = FMT_1;
    e_b0      = b0_q;
    e_b1      = '0;
    e_b2      = '0;
    e_b3      = '0;
    emit_inv  = 1'b0;
    emit_pre  = 1'b0;
    emit_nop  = 1'b0;
    emit_halt = 1'b0;
    if (accept) begin
      case (state_q)
        ST_OP: begin
          e_b0 = fetch_byte;
          if (c_inv) begin
            emit     = 1'b1;
            emit_inv = 1'b1;
          end else if (c_f1) begin
            emit      = 1'b1;
            emit_pre  = c_pre;
            emit_nop  = c_nop;
            emit_halt = c_halt;
          end else begin
            state_d = ST_B1;
          end
        end
        ST_B1: begin
          if (kind_f2_q) begin
            emit     = 1'b1;
            emit_fmt = FMT_2;
            e_b1     = fetch_byte;
            state_d  = ST_OP;
          end else begin
            state_d = ST_B2;
          end
        end
        ST_B2: begin
          if (b1_q[E_POS]) begin
            state_d = ST_B3;
          end else begin
            emit     = 1'b1;
            emit_fmt = FMT_3;
            e_b1     = b1_q;
            e_b2     = fetch_byte;
            state_d  = ST_OP;
          end
        end
        default: begin
          emit     = 1'b1;
          emit_fmt = FMT_4;
          e_b1     = b1_q;
          e_b2     = b2_q;
          e_b3     = fetch_byte;
          state_d  = ST_OP;
        end
      endcase
    end
  end

  pfx_field_extract fx_i (
    .fmt    (emit_fmt),
    .b0     (e_b0),
    .b1     (e_b1),
    .b2     (e_b2),
    .b3     (e_b3),
    .opcode (x_opcode),
    .r1     (x_r1),
    .r2     (x_r2),
    .flags  (x_flags),
    .addr   (x_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OP;
      b0_q        <= '0;
      b1_q        <= '0;
      b2_q        <= '0;
      kind_f2_q   <= 1'b0;
      pending_q   <= 1'b0;
      halted_q    <= 1'b0;
      dec_valid   <= 1'b0;
      dec_ext_map <= 1'b0;
      dec_fmt_q   <= FMT_1;
      dec_opcode  <= '0;
      dec_r1      <= '0;
      dec_r2      <= '0;
      dec_flags   <= '0;
      dec_addr    <= '0;
      dec_invalid <= 1'b0;
      dec_halt    <= 1'b0;
      dec_nop     <= 1'b0;
      dec_prefix  <= 1'b0;
    end else begin
      state_q   <= state_d;
      dec_valid <= emit;
      if (accept) begin
        case (state_q)
          ST_OP: begin
            b0_q      <= fetch_byte;
            kind_f2_q <= c_f2;
          end
          ST_B1:   b1_q <= fetch_byte;
          ST_B2:   b2_q <= fetch_byte;
          default: ;
        endcase
      end
      if (emit) begin
        dec_ext_map <= pending_q;
        dec_fmt_q   <= emit_fmt;
        dec_opcode  <= x_opcode;
        dec_r1      <= x_r1;
        dec_r2      <= x_r2;
        dec_flags   <= x_flags;
        dec_addr    <= x_addr;
        dec_invalid <= emit_inv;
        dec_halt    <= emit_halt;
        dec_nop     <= emit_nop;
        dec_prefix  <= emit_pre;
        // One-shot map switch: only a prefix leaves the extended map armed.
        pending_q   <= emit_pre;
        if (emit_halt) halted_q <= 1'b1;
      end
    end
  end

  // R11: halt is sticky and silences the decoder.
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q);
  p_quiet_after_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (halted_q && $past(halted_q)) |-> !dec_valid);
  p_halt_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_halt) |-> halted_q);
  // R8: a decoded prefix arms the extended map.
  p_prefix_arms_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_prefix) |-> pending_q);
  // R10: any other record disarms it.
  p_one_shot_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_prefix) |-> !pending_q);
  // R9: base-only one-byte specials never decode in the extended map.
  p_ext_no_specials_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_ext_map) |-> !(dec_prefix || dec_halt || dec_nop));
  // R7: an invalid record has the one-byte shape and no other kind.
  p_invalid_shape_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_invalid) |->
      (dec_fmt == 2'd0 && dec_flags == '0 && dec_addr == '0 && dec_r1 == '0));
  p_kind_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $onehot0({dec_invalid, dec_halt, dec_nop, dec_prefix}));
  // R5: a three-byte form carries a short displacement only.
  p_short_disp_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_fmt == 2'd2) |-> (dec_addr[ADDR_W-1:DISP_W] == '0));
  // R12: a record follows a taken byte.
  p_rec_after_take_r12: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(accept));

endmodule

// File: tb/pfx_fmt_decoder_tb.sv
module pfx_fmt_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [7:0]  fetch_byte = 8'h00;
  logic        fetch_ready;
  logic        dec_valid, dec_ext_map, dec_invalid, dec_halt, dec_nop, dec_prefix, halted;
  logic [1:0]  dec_fmt;
  logic [7:0]  dec_opcode;
  logic [3:0]  dec_r1, dec_r2;
  logic [5:0]  dec_flags;
  logic [19:0] dec_addr;

  int n_chk = 0;
  int n_err = 0;
  bit m_pend = 1'b0;

  always #5 clk = ~clk;

  pfx_fmt_decoder dut_i (
    .clk (clk), .rst (rst), .fetch_valid (fetch_valid), .fetch_byte (fetch_byte),
    .fetch_ready (fetch_ready), .dec_valid (dec_valid), .dec_ext_map (dec_ext_map),
    .dec_fmt (dec_fmt), .dec_opcode (dec_opcode), .dec_r1 (dec_r1), .dec_r2 (dec_r2),
    .dec_flags (dec_flags), .dec_addr (dec_addr), .dec_invalid (dec_invalid),
    .dec_halt (dec_halt), .dec_nop (dec_nop), .dec_prefix (dec_prefix), .halted (halted)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 one-byte, 2 two-byte, 3 memory form
  function automatic int base_kind(input logic [7:0] v);
    if (v inside {8'hEE, 8'hF1, 8'hF2, 8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8}) return 1;
    if (v % 4 == 0 && v inside {[8'h90:8'hB8]}) return 2;
    if (v % 4 == 0 && (v inside {[8'h00:8'h88]} || v inside {[8'hD0:8'hE0]} || v == 8'hE8 || v == 8'hEC)) return 3;
    return 0;
  endfunction

  function automatic int ext_kind(input logic [7:0] v);
    if (v inside {8'h90, 8'h94, 8'h98, 8'h9C}) return 2;
    if (v inside {8'h00, 8'h04, 8'h0C, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h68, 8'h7C, 8'h84}) return 3;
    return 0;
  endfunction

  // Record: {ext, fmt, op, r1, r2, flags, addr, inv, halt, nop, pre}
  task automatic model(input logic [7:0] b0, b1, b2, b3, output int len, output logic [48:0] rec);
    int kf, km;
    logic [1:0] f; logic [7:0] op; logic [3:0] ra, rb; logic [5:0] fl; logic [19:0] ad;
    logic inv, hl, np, pr;
    kf = m_pend ? ext_kind(b0) : base_kind(b0);
    km = m_pend ? ext_kind(b0 & 8'hFC) : base_kind(b0 & 8'hFC);
    f = 0; op = b0; ra = 0; rb = 0; fl = 0; ad = 0; inv = 0; hl = 0; np = 0; pr = 0;
    if (kf == 1) begin
      len = 1;
      pr = !m_pend && b0 == 8'hEE; np = !m_pend && b0 == 8'hF1; hl = !m_pend && b0 == 8'hF2;
    end else if (kf == 2) begin
      len = 2; f = 1; ra = b1[7:4]; rb = b1[3:0];
    end else if (km == 3) begin
      op = {b0[7:2], 2'b00}; fl = {b0[1], b0[0], b1[7], b1[6], b1[5], b1[4]};
      if (b1[4]) begin len = 4; f = 3; ad = {b1[3:0], b2, b3}; end
      else begin len = 3; f = 2; ad = {8'h00, b1[3:0], b2}; end
    end else begin
      len = 1; inv = 1;
    end
    rec = {m_pend, f, op, ra, rb, fl, ad, inv, hl, np, pr};
    m_pend = pr;
  endtask

  task automatic run_insn(input string tag, input logic [7:0] b0, b1, b2, b3, input int max_gap);
    int len; logic [48:0] exp; logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    model(b0, b1, b2, b3, len, exp);
    for (int k = 0; k < len; k++) begin
      int gap;
      gap = (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0;
      for (int g = 0; g < gap; g++) begin
        fetch_valid = 1'b0;
        @(negedge clk);
      end
      fetch_valid = 1'b1;
      fetch_byte  = bs[k];
      @(negedge clk);
      if (k < len - 1) chk({tag, " R12 no early record"}, 64'(dec_valid), 64'd0);
    end
    fetch_valid = 1'b0;
    chk({tag, " R12 record strobe"}, 64'(dec_valid), 64'd1);
    chk({tag, " record"}, 64'({dec_ext_map, dec_fmt, dec_opcode, dec_r1, dec_r2, dec_flags,
                               dec_addr, dec_invalid, dec_halt, dec_nop, dec_prefix}), 64'(exp));
  endtask

  task automatic do_reset();
    rst = 1'b1; fetch_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; m_pend = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk("R1 valid after reset", 64'(dec_valid), 64'd0);
    chk("R1 ready after reset", 64'(fetch_ready), 64'd1);
    chk("R1 halted after reset", 64'(halted), 64'd0);

    run_insn("R2 one-byte C4", 8'hC4, 0, 0, 0, 0);
    run_insn("R2 no-op", 8'hF1, 0, 0, 0, 1);
    run_insn("R3 two-byte B4", 8'hB4, 8'h5A, 0, 0, 2);
    run_insn("R4 R5 three-byte", 8'h1B, 8'h2A, 8'hBC, 0, 2);
    run_insn("R4 R5 four-byte", 8'h03, 8'h9F, 8'h12, 8'h34, 2);
    run_insn("R6 R7 byte 91", 8'h91, 0, 0, 0, 0);
    run_insn("R6 R7 byte F3", 8'hF3, 0, 0, 0, 0);
    run_insn("R6 byte ED", 8'hED, 8'h01, 8'h02, 0, 1);
    run_insn("R8 prefix", 8'hEE, 0, 0, 0, 0);
    run_insn("R8 R9 ext 90", 8'h90, 8'h40, 0, 0, 1);
    run_insn("R8 base 90 again", 8'h90, 8'h40, 0, 0, 0);
    run_insn("R8 prefix", 8'hEE, 0, 0, 0, 0);
    run_insn("R9 ext B4 invalid", 8'hB4, 0, 0, 0, 0);
    run_insn("R10 base B4 after invalid", 8'hB4, 8'h10, 0, 0, 0);
    run_insn("R8 prefix", 8'hEE, 0, 0, 0, 0);
    run_insn("R9 R10 ext prefix invalid", 8'hEE, 0, 0, 0, 0);
    run_insn("R10 base C0", 8'hC0, 0, 0, 0, 0);
    run_insn("R8 prefix", 8'hEE, 0, 0, 0, 0);
    run_insn("R9 ext four-byte 68", 8'h6B, 8'h10, 8'h02, 8'h00, 2);
    run_insn("R8 prefix", 8'hEE, 0, 0, 0, 0);
    run_insn("R9 ext halt byte invalid", 8'hF2, 0, 0, 0, 0);
    chk("R9 not halted", 64'(halted), 64'd0);
    run_insn("R8 prefix", 8'hEE, 0, 0, 0, 0);
    do_reset();
    run_insn("R1 base after reset", 8'h90, 8'h40, 0, 0, 0);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] r0;
      r0 = 8'($urandom);
      if ($urandom % 3 == 0 && !m_pend) r0 = 8'hEE;
      if (!m_pend && r0 == 8'hF2) r0 = 8'hF1;
      run_insn("R12 random", r0, 8'($urandom), 8'($urandom), 8'($urandom), 2);
    end

    if (m_pend) run_insn("R10 drain", 8'hC8, 0, 0, 0, 0);
    run_insn("R11 halt", 8'hF2, 0, 0, 0, 0);
    chk("R11 halted set", 64'(halted), 64'd1);
    for (int k = 0; k < 4; k++) begin
      fetch_valid = 1'b1; fetch_byte = 8'hF1;
      @(negedge clk);
      chk("R11 ready low", 64'(fetch_ready), 64'd0);
      chk("R11 no record", 64'(dec_valid), 64'd0);
    end
    do_reset();
    chk("R1 halt cleared", 64'(halted), 64'd0);
    chk("R1 ready restored", 64'(fetch_ready), 64'd1);
    run_insn("R1 decode resumes", 8'hC4, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule